// File: doc/BRIEF.md
# Flash Bus Command Sequence Decoder

This block sits behind the write side of a parallel NOR flash bus. Each bus write arrives as a one-cycle strobe carrying an address and an 8-bit data value. The decoder follows the unlock-prefixed write sequences that a host uses to request work from the flash. When a sequence completes, it raises one pulse that carries a command code together with the address and data of the final write. The embedded program and erase engines consume these pulses. Those engines, and the array they drive, are outside this block.

The decoder also holds the access mode that the read path needs: normal read, identification, query table, or the sticky single-pulse program mode. In single-pulse program mode, every write becomes a program request. A busy flag from the embedded engine stops command decoding while a program runs. The single-cycle suspend request is the only thing that still gets through.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `mode` is 0 (read), `cmd_valid` is 0 and `cmd_code` is 0.
- R2: Every multi-write sequence opens with data AA at address 555h, then data 55 at address 2AAh. Only address bits 10..0 are compared, so AAAh and any higher address bits still match. A prefix at any other low address starts nothing.
- R3: A third write at 555h with data 90 gives code 8 (identify entry) and mode 1. With data F0 it gives code 9 (identify exit) and mode 0.
- R4: A third write at 555h of A0, C0 or D0 waits for a fourth write at any address. That fourth write gives code 5 (program), code 7 (protection register write) or code 10 (configuration set). Code 10 is given only for fourth-write data 00 or 01; any other data gives no pulse.
- R5: A third write at 555h of E0 takes two more writes. The fourth write gives no pulse. The fifth gives code 6 (dual program) with the fifth write's address and data.
- R6: A third write at 555h of 80, followed by AA at 555h and 55 at 2AAh, leads to a sixth write. That write gives code 1 (chip erase) for 10 at 555h, code 2 (sector erase) for 30 at any address, code 3 (sector lock) for 60 at any address, and code 4 (single-pulse entry, mode 3) for A0 at 555h.
- R7: With no sequence in progress, a single write at any address gives code 11 for data B0 (suspend), code 12 for data 30 (resume) and code 9 for data F0 (identify exit, mode 0).
- R8: Data 98 at low address 055h gives code 13 and mode 2 (query), but only in mode 0 or mode 1. In mode 2 it gives no pulse. Code 9 returns mode 2 to mode 0.
- R9: A write that does not fit the next expected step gives no pulse and drops the decoder back to idle. A new sequence must then start again with the first prefix write.
- R10: While `eng_busy` is 1, writes raise no pulse and leave the sequence position and mode unchanged. The one exception is data B0 with no sequence in progress, which still gives code 11.
- R11: In mode 3, every write gives code 14 with its own address and data, including writes of B0, 30, F0 and AA. Writes made while `eng_busy` is 1 are ignored. Mode 3 is left only by reset.
- R12: The pulse is registered. `cmd_valid` is high for exactly the one cycle after the clock edge that samples the completing write, and it carries that write's address and data. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| eng_busy | input | 1 | Embedded program or erase running |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 4 | Command code (see R3 to R11) |
| cmd_addr | output | ADDR_W | Address of the completing write |
| cmd_data | output | 8 | Data of the completing write |
| mode | output | 2 | 0 read, 1 identify, 2 query, 3 single-pulse program |

## Verification
The embedded properties assume a few things about the inputs. `wr_stb` is a clean single-cycle strobe with its address and data stable in that cycle. `eng_busy` changes only between writes, never inside the cycle that completes a sequence. The directed stimulus drives every input on the falling clock edge and holds a strobe for exactly one cycle. It raises or drops the busy flag only between whole write tasks, including once partway through a prefix, to show that the sequence position is kept. Reset is applied only between scenarios, which is also the only way the single-pulse program test leaves mode 3.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        CMD_NONE       = 4'd0,
        CMD_CHIP_ERASE = 4'd1,
        CMD_SECT_ERASE = 4'd2,
        CMD_SECT_LOCK  = 4'd3,
        CMD_SPP_ENTER  = 4'd4,
        CMD_PROGRAM    = 4'd5,
        CMD_DUAL_PROG  = 4'd6,
        CMD_PREG_WRITE = 4'd7,
        CMD_ID_ENTER   = 4'd8,
        CMD_ID_EXIT    = 4'd9,
        CMD_SET_CFG    = 4'd10,
        CMD_SUSPEND    = 4'd11,
        CMD_RESUME     = 4'd12,
        CMD_QRY_ENTER  = 4'd13,
        CMD_SPP_PROG   = 4'd14
    } cmd_e;

    typedef enum logic [1:0] {
        MODE_READ = 2'd0,
        MODE_ID   = 2'd1,
        MODE_QRY  = 2'd2,
        MODE_SPP  = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_X1, SQ_X2, SQ_X3,
        SQ_PGM, SQ_DUAL1, SQ_DUAL2, SQ_PREG, SQ_CFG
    } seq_e;

    typedef struct packed {
        logic vld;
        cmd_e code;
    } hit_t;

    // Command addresses (low bits only are compared)
    localparam logic [11:0] ADR_FIRST  = 12'h555;
    localparam logic [11:0] ADR_SECOND = 12'h2AA;
    localparam logic [11:0] ADR_QUERY  = 12'h055;

    // Data codes
    localparam logic [7:0] D_KEY1    = 8'hAA;
    localparam logic [7:0] D_KEY2    = 8'h55;
    localparam logic [7:0] D_EXT     = 8'h80;
    localparam logic [7:0] D_PGM     = 8'hA0;
    localparam logic [7:0] D_DUAL    = 8'hE0;
    localparam logic [7:0] D_PREG    = 8'hC0;
    localparam logic [7:0] D_CFG     = 8'hD0;
    localparam logic [7:0] D_ID_IN   = 8'h90;
    localparam logic [7:0] D_ID_OUT  = 8'hF0;
    localparam logic [7:0] D_SUSPEND = 8'hB0;
    localparam logic [7:0] D_RESUME  = 8'h30;
    localparam logic [7:0] D_CHIP    = 8'h10;
    localparam logic [7:0] D_LOCK    = 8'h60;
    localparam logic [7:0] D_QUERY   = 8'h98;

    function automatic hit_t make_hit(input cmd_e c);
        hit_t h;
        h.vld  = 1'b1;
        h.code = c;
        return h;
    endfunction

endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int CMP_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic [CMP_W-1:0] adr_lo,
    input  logic [7:0]       data,
    input  logic             busy,
    input  mode_e            mode,
    output hit_t             hit
);

    localparam logic [CMP_W-1:0] K_FIRST  = CMP_W'(ADR_FIRST);
    localparam logic [CMP_W-1:0] K_SECOND = CMP_W'(ADR_SECOND);
    localparam logic [CMP_W-1:0] K_QUERY  = CMP_W'(ADR_QUERY);

    seq_e state, nxt;
    logic at_first, at_second, at_query;

    assign at_first  = (adr_lo == K_FIRST);
    assign at_second = (adr_lo == K_SECOND);
    assign at_query  = (adr_lo == K_QUERY);

    always_comb begin
        nxt      = state;
        hit.vld  = 1'b0;
        hit.code = CMD_NONE;
        if (stb) begin
            if (mode == MODE_SPP) begin
                if (!busy) hit = make_hit(CMD_SPP_PROG);
            end else if (busy) begin
                if (state == SQ_IDLE && data == D_SUSPEND) hit = make_hit(CMD_SUSPEND);
            end else begin
                nxt = SQ_IDLE;
                unique case (state)
                    SQ_IDLE: begin
                        if (data == D_KEY1 && at_first)   nxt = SQ_U1;
                        else if (data == D_SUSPEND)       hit = make_hit(CMD_SUSPEND);
                        else if (data == D_RESUME)        hit = make_hit(CMD_RESUME);
                        else if (data == D_ID_OUT)        hit = make_hit(CMD_ID_EXIT);
                        else if (data == D_QUERY && at_query && mode != MODE_QRY)
                                                          hit = make_hit(CMD_QRY_ENTER);
                    end
                    SQ_U1: if (data == D_KEY2 && at_second) nxt = SQ_U2;
                    SQ_U2: begin
                        if (at_first) begin
                            case (data)
                                D_EXT:    nxt = SQ_X1;
                                D_PGM:    nxt = SQ_PGM;
                                D_DUAL:   nxt = SQ_DUAL1;
                                D_PREG:   nxt = SQ_PREG;
                                D_CFG:    nxt = SQ_CFG;
                                D_ID_IN:  hit = make_hit(CMD_ID_ENTER);
                                D_ID_OUT: hit = make_hit(CMD_ID_EXIT);
                                default:  nxt = SQ_IDLE;
                            endcase
                        end
                    end
                    SQ_X1: if (data == D_KEY1 && at_first)  nxt = SQ_X2;
                    SQ_X2: if (data == D_KEY2 && at_second) nxt = SQ_X3;
                    SQ_X3: begin
                        if (data == D_CHIP && at_first)      hit = make_hit(CMD_CHIP_ERASE);
                        else if (data == D_RESUME)           hit = make_hit(CMD_SECT_ERASE);
                        else if (data == D_LOCK)             hit = make_hit(CMD_SECT_LOCK);
                        else if (data == D_PGM && at_first)  hit = make_hit(CMD_SPP_ENTER);
                    end
                    SQ_PGM:   hit = make_hit(CMD_PROGRAM);
                    SQ_DUAL1: nxt = SQ_DUAL2;
                    SQ_DUAL2: hit = make_hit(CMD_DUAL_PROG);
                    SQ_PREG:  hit = make_hit(CMD_PREG_WRITE);
                    SQ_CFG: begin
                        if (data == 8'h00 || data == 8'h01) hit = make_hit(CMD_SET_CFG);
                    end
                    default: nxt = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= nxt;
    end

    // R10: a busy engine (or no write) leaves the sequence position untouched
    a_r10_busy_holds_state: assert property (@(posedge clk) disable iff (rst)
        (busy || !stb) |=> state == $past(state));

    // R9: every completed command leaves the tracker at idle
    a_r9_idle_after_hit: assert property (@(posedge clk) disable iff (rst)
        hit.vld |=> state == SQ_IDLE);

endmodule

// File: rtl/fcd_mode_reg.sv
module fcd_mode_reg
    import fcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  hit_t  hit,
    output mode_e mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_READ;
        end else if (hit.vld && mode != MODE_SPP) begin
            case (hit.code)
                CMD_ID_ENTER:  mode <= MODE_ID;
                CMD_ID_EXIT:   mode <= MODE_READ;
                CMD_QRY_ENTER: mode <= MODE_QRY;
                CMD_SPP_ENTER: mode <= MODE_SPP;
                default:       mode <= mode;
            endcase
        end
    end

    // R11: single-pulse program mode is only left by reset
    a_r11_spp_sticky: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_SPP |=> mode == MODE_SPP);

    // R8: an accepted query request lands in query mode
    a_r8_query_entry: assert property (@(posedge clk) disable iff (rst)
        (hit.vld && hit.code == CMD_QRY_ENTER) |=> mode == MODE_QRY);

endmodule

// File: rtl/fcd_out_reg.sv
module fcd_out_reg
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  hit_t              hit,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              valid_q,
    output cmd_e              code_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            code_q  <= CMD_NONE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            valid_q <= hit.vld;
            code_q  <= hit.vld ? hit.code : CMD_NONE;
            if (hit.vld) begin
                addr_q <= addr_in;
                data_q <= data_in;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CMP_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              eng_busy,
    output logic              cmd_valid,
    output logic [3:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic [1:0]        mode
);

    hit_t  hit;
    mode_e mode_q;
    cmd_e  code_q;

    fcd_seq_fsm #(.CMP_W(CMP_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .stb    (wr_stb),
        .adr_lo (wr_addr[CMP_W-1:0]),
        .data   (wr_data),
        .busy   (eng_busy),
        .mode   (mode_q),
        .hit    (hit)
    );

    fcd_mode_reg u_mode (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit),
        .mode (mode_q)
    );

    fcd_out_reg #(.ADDR_W(ADDR_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .addr_in (wr_addr),
        .data_in (wr_data),
        .valid_q (cmd_valid),
        .code_q  (code_q),
        .addr_q  (cmd_addr),
        .data_q  (cmd_data)
    );

    assign cmd_code = code_q;
    assign mode     = mode_q;

    // R12: a pulse always follows a sampled write
    a_r12_pulse_needs_write: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(wr_stb));

    // R12: the pulse carries the completing write's address and data
    a_r12_capture: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data)));

    // R12: a pulse never carries the empty code
    a_r12_code_present: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> code_q != CMD_NONE);

    // R11: in single-pulse mode only program requests come out
    a_r11_spp_only_prog: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(mode_q) == MODE_SPP) |-> code_q == CMD_SPP_PROG);

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

    localparam int AW = 20;

    localparam int C_NONE = 0, C_CHIP = 1, C_SECT = 2, C_LOCK = 3, C_SPPIN = 4,
                   C_PGM = 5, C_DUAL = 6, C_PREG = 7, C_IDIN = 8, C_IDOUT = 9,
                   C_CFG = 10, C_SUSP = 11, C_RES = 12, C_QRY = 13, C_SPPPG = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stb = 1'b0;
    logic          busy = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data = '0;

    logic          cmd_valid;
    logic [3:0]    cmd_code;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_data;
    logic [1:0]    mode;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .CMP_W(11)) u0 (
        .clk(clk), .rst(rst), .wr_stb(stb), .wr_addr(addr), .wr_data(data),
        .eng_busy(busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .mode(mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write presented on one falling edge, result visible on the next
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; data = d; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic expect_cmd(input string req, input int code,
                              input logic [AW-1:0] a, input logic [7:0] d);
        check({req, " valid"}, cmd_valid, 1);
        check({req, " code"}, cmd_code, code);
        check({req, " addr"}, cmd_addr, a);
        check({req, " data"}, cmd_data, d);
    endtask

    task automatic expect_none(input string req);
        check({req, " no pulse"}, cmd_valid, 0);
    endtask

    task automatic unlock(input string req);
        wr(20'h00555, 8'hAA); expect_none(req);
        wr(20'h00AAA, 8'h55); expect_none(req);
    endtask

    task automatic ext_prefix(input string req);
        unlock(req);
        wr(20'h00555, 8'h80); expect_none(req);
        unlock(req);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 valid", cmd_valid, 0);
        check("R1 mode", mode, 0);
        check("R1 code", cmd_code, C_NONE);
    endtask

    task automatic t_alias();
        wr(20'h00555, 8'hAA); expect_none("R2");
        wr(20'hF52AA, 8'h55); expect_none("R2");
        wr(20'h3D555, 8'hA0); expect_none("R2");
        wr(20'h12345, 8'h5A); expect_cmd("R2 alias program", C_PGM, 20'h12345, 8'h5A);
        @(negedge clk);
        check("R12 one cycle", cmd_valid, 0);
        wr(20'h00554, 8'hAA); expect_none("R2 bad addr");
        wr(20'h00AAA, 8'h55); expect_none("R2 bad addr");
        wr(20'h00555, 8'hA0); expect_none("R2 bad addr");
        wr(20'h00100, 8'h11); expect_none("R2 bad addr");
    endtask

    task automatic t_id();
        unlock("R3");
        wr(20'h00555, 8'h90); expect_cmd("R3 id entry", C_IDIN, 20'h00555, 8'h90);
        check("R3 mode id", mode, 1);
        unlock("R3");
        wr(20'h00555, 8'hF0); expect_cmd("R3 id exit", C_IDOUT, 20'h00555, 8'hF0);
        check("R3 mode read", mode, 0);
    endtask

    task automatic t_four();
        unlock("R4");
        wr(20'h00555, 8'hC0); expect_none("R4");
        wr(20'h00080, 8'h00); expect_cmd("R4 preg", C_PREG, 20'h00080, 8'h00);
        unlock("R4");
        wr(20'h00555, 8'hD0); expect_none("R4");
        wr(20'h00000, 8'h01); expect_cmd("R4 cfg", C_CFG, 20'h00000, 8'h01);
        unlock("R4");
        wr(20'h00555, 8'hD0); expect_none("R4");
        wr(20'h00000, 8'h02); expect_none("R4 cfg bad data");
        unlock("R4");
        wr(20'h00555, 8'hA0); expect_none("R4");
        wr(20'h0ABCD, 8'h3C); expect_cmd("R4 program", C_PGM, 20'h0ABCD, 8'h3C);
    endtask

    task automatic t_dual();
        unlock("R5");
        wr(20'h00555, 8'hE0); expect_none("R5");
        wr(20'h00100, 8'h11); expect_none("R5 fourth");
        wr(20'h00101, 8'h22); expect_cmd("R5 dual", C_DUAL, 20'h00101, 8'h22);
    endtask

    task automatic t_erase();
        ext_prefix("R6");
        wr(20'h00555, 8'h10); expect_cmd("R6 chip", C_CHIP, 20'h00555, 8'h10);
        ext_prefix("R6");
        wr(20'h48000, 8'h30); expect_cmd("R6 sector", C_SECT, 20'h48000, 8'h30);
        ext_prefix("R6");
        wr(20'h09000, 8'h60); expect_cmd("R6 lock", C_LOCK, 20'h09000, 8'h60);
        check("R6 mode unchanged", mode, 0);
    endtask

    task automatic t_single();
        wr(20'h01234, 8'hB0); expect_cmd("R7 suspend", C_SUSP, 20'h01234, 8'hB0);
        wr(20'h00777, 8'h30); expect_cmd("R7 resume", C_RES, 20'h00777, 8'h30);
        wr(20'h00000, 8'hF0); expect_cmd("R7 id exit", C_IDOUT, 20'h00000, 8'hF0);
    endtask

    task automatic t_query();
        wr(20'h00056, 8'h98); expect_none("R8 wrong addr");
        wr(20'h00055, 8'h98); expect_cmd("R8 query", C_QRY, 20'h00055, 8'h98);
        check("R8 mode query", mode, 2);
        wr(20'h00055, 8'h98); expect_none("R8 repeat");
        check("R8 mode kept", mode, 2);
        wr(20'h00000, 8'hF0); expect_cmd("R8 exit", C_IDOUT, 20'h00000, 8'hF0);
        check("R8 mode read", mode, 0);
        unlock("R8");
        wr(20'h00555, 8'h90); expect_cmd("R8 id", C_IDIN, 20'h00555, 8'h90);
        wr(20'h00055, 8'h98); expect_cmd("R8 query from id", C_QRY, 20'h00055, 8'h98);
        check("R8 mode query2", mode, 2);
        wr(20'h00000, 8'hF0); expect_cmd("R8 exit2", C_IDOUT, 20'h00000, 8'hF0);
        check("R8 mode read2", mode, 0);
    endtask

    task automatic t_mismatch();
        wr(20'h00555, 8'hAA); expect_none("R9");
        wr(20'h00555, 8'h55); expect_none("R9 wrong step");
        wr(20'h00555, 8'hA0); expect_none("R9 restarted");
        wr(20'h00010, 8'h33); expect_none("R9 restarted");
        unlock("R9");
        wr(20'h00555, 8'h80); expect_none("R9");
        wr(20'h00555, 8'hAA); expect_none("R9");
        wr(20'h002AA, 8'h56); expect_none("R9 wrong data");
        wr(20'h00555, 8'h10); expect_none("R9 no chip erase");
    endtask

    task automatic t_busy();
        busy = 1'b1;
        unlock("R10");
        wr(20'h00555, 8'hA0); expect_none("R10");
        wr(20'h00020, 8'h44); expect_none("R10 program ignored");
        wr(20'h00000, 8'hB0); expect_cmd("R10 suspend", C_SUSP, 20'h00000, 8'hB0);
        wr(20'h00000, 8'h30); expect_none("R10 resume ignored");
        wr(20'h00055, 8'h98); expect_none("R10 query ignored");
        check("R10 mode kept", mode, 0);
        busy = 1'b0;
        wr(20'h00020, 8'h44); expect_none("R10 still idle");
        unlock("R10");
        busy = 1'b1;
        wr(20'h00555, 8'hA0); expect_none("R10 held");
        busy = 1'b0;
        wr(20'h00555, 8'hA0); expect_none("R10");
        wr(20'h00030, 8'h99); expect_cmd("R10 position kept", C_PGM, 20'h00030, 8'h99);
    endtask

    task automatic t_spp();
        ext_prefix("R11");
        wr(20'h00555, 8'hA0); expect_cmd("R11 enter", C_SPPIN, 20'h00555, 8'hA0);
        check("R11 mode spp", mode, 3);
        wr(20'h00555, 8'hB0); expect_cmd("R11 B0 as data", C_SPPPG, 20'h00555, 8'hB0);
        wr(20'h00000, 8'h30); expect_cmd("R11 30 as data", C_SPPPG, 20'h00000, 8'h30);
        wr(20'h00000, 8'hF0); expect_cmd("R11 F0 as data", C_SPPPG, 20'h00000, 8'hF0);
        wr(20'h00555, 8'hAA); expect_cmd("R11 AA as data", C_SPPPG, 20'h00555, 8'hAA);
        check("R11 mode sticky", mode, 3);
        busy = 1'b1;
        wr(20'h00040, 8'h12); expect_none("R11 busy");
        busy = 1'b0;
        do_reset();
        check("R11 reset leaves", mode, 0);
        check("R1 valid after reset", cmd_valid, 0);
        wr(20'h00000, 8'hB0); expect_cmd("R11 decoding back", C_SUSP, 20'h00000, 8'hB0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_alias();
        t_id();
        t_four();
        t_dual();
        t_erase();
        t_single();
        t_query();
        t_mismatch();
        t_busy();
        t_spp();
        summary();
        $finish;
    end

endmodule